// File: doc/BRIEF.md
# Threshold-Shared Serial 4-bit S-box Sequencer

This block evaluates a 4-bit substitution box on data that arrives split into three Boolean shares. It never recombines the shares and uses no random bits. The nonlinear layer is a rotation-invariant quadratic permutation. It is computed one output bit per cycle by a single shared gadget. Each gadget evaluation sees only two of the three input shares. Between nonlinear layers, each share passes separately through a linear diffusion step. That step is a one-bit left shift followed by a constant XOR that is gated by the bit shifted out, and it is applied twice.

To use the block, drive three shares whose XOR is the secret nibble and pulse `start` while the block is idle. After a fixed number of cycles `done` pulses for one cycle. The three output shares then hold a sharing of the substituted nibble until the next accepted start. Each round takes twelve nonlinear cycles and two linear cycles, so two rounds take 28 cycles. In the final round the two linear slots only move the result into the output register. This keeps the latency the same for every round and every input.

Top module: `ti_spn_sbox`

## Requirements
- R1: While reset is held and just after it is released, `busy` and `done` are 0 and all three output shares are zero.
- R2: A `start` that is sampled high while `busy` is 0 captures the three input shares, and `busy` is 1 from the following cycle.
- R3: `done` rises exactly 28 clock edges after the edge that accepted `start`. It is high for one cycle only, and `busy` is 0 in that cycle.
- R4: Bit 3 of each nibble is the top bit. The S-box is the nonlinear layer Q, then the linear map L applied twice, then Q again. Output bit i of Q is x[i] ^ x[i-1]x[i] ^ x[i+1]x[i+2] ^ x[i]x[i+2] ^ x[i+1]x[i+3], with indices taken mod 4. L shifts left by one with zero fill, then XORs 4'hF when the top bit before the shift was 1. For inputs 0 to F, the XOR of the output shares is 0,4,8,A,F,C,6,9,1,E,B,D,7,5,3,2 in that order.
- R5: The recombined result depends only on the XOR of the input shares, and not on how that value is split among them.
- R6: A `start` pulse while `busy` is 1 is ignored: the running evaluation keeps its latency and its result.
- R7: Once `done` has pulsed, the output shares stay constant, whatever the input shares do, until a new `start` is accepted.
- R8: An all-zero sharing gives three all-zero output shares, because no constant or fresh random value enters any share.
- R9: The block is deterministic. Evaluating the same sharing twice gives identical output shares, share by share.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin an evaluation; honoured only while idle |
| sh_in0 | input | 4 | Input share 0 |
| sh_in1 | input | 4 | Input share 1 |
| sh_in2 | input | 4 | Input share 2 |
| sh_out0 | output | 4 | Output share 0 |
| sh_out1 | output | 4 | Output share 1 |
| sh_out2 | output | 4 | Output share 2 |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse when the output shares are final |

## Verification
The embedded properties assume that reset is applied before the first evaluation. They also assume that `start` and the input shares carry defined values at every sampled edge. The hold and pulse checks further assume that nothing other than an accepted `start` should move the outputs. The bench meets these assumptions by holding reset for several cycles and by changing every input on the falling edge only. It also keeps `start` defined at all times. Pulses during `busy` and input changes after `done` are injected on purpose, at falling edges, so that the ignore rule and the hold rule are exercised.

// File: rtl/ti_sbox_pkg.sv
package ti_sbox_pkg;

   localparam int NUM_SHARES = 3;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_NONLIN = 2'd1,
      PH_LIN    = 2'd2
   } ti_phase_e;

   // shared product term for one pair of bit positions; ua/ub from the
   // first visible share, va/vb from the second visible share
   function automatic logic ti_cross(input logic ua, input logic ub,
                                     input logic va, input logic vb);
      return (ua & ub) ^ (ua & vb) ^ (va & ub);
   endfunction

endpackage

// File: rtl/ti_sbox_rot.sv
module ti_sbox_rot #(
   parameter int N  = 4,
   parameter int AW = 2
) (
   input  logic [N-1:0]  din,
   input  logic [AW-1:0] amt,
   output logic [N-1:0]  dout
);

   if (N < 2) begin : g_chk_width
      $error("ti_sbox_rot: N must be at least 2");
   end

   // right rotation: bit amt of din lands at bit 0 of dout
   always_comb begin
      for (int b = 0; b < N; b++) begin
         int idx;
         idx = b + int'(amt);
         if (idx >= N) idx = idx - N;
         dout[b] = din[idx];
      end
   end

endmodule

// File: rtl/ti_sbox_gadget.sv
module ti_sbox_gadget
   import ti_sbox_pkg::*;
#(
   parameter int N = 4
) (
   input  logic [N-1:0] u,   // first share not owned by the output share
   input  logic [N-1:0] v,   // second share not owned by the output share
   output logic         y
);

   if (N != 4) begin : g_chk_width
      $error("ti_sbox_gadget: the quadratic form is defined for N == 4 only");
   end

   // output bit 0 of one share; bits i>0 come from rotated operands
   assign y = u[0]
            ^ ti_cross(u[3], u[0], v[3], v[0])
            ^ ti_cross(u[1], u[2], v[1], v[2])
            ^ ti_cross(u[0], u[2], v[0], v[2])
            ^ ti_cross(u[1], u[3], v[1], v[3]);

endmodule

// File: rtl/ti_sbox_lin.sv
module ti_sbox_lin #(
   parameter int         N = 4,
   parameter logic [N-1:0] K = 4'hF
) (
   input  logic [N-1:0] x,
   output logic [N-1:0] y
);

   if (K[0] != 1'b1) begin : g_chk_const
      $error("ti_sbox_lin: K[0] must be 1 for the map to be invertible");
   end

   // shift plus masked constant: no data-dependent control flow
   assign y = {x[N-2:0], 1'b0} ^ (K & {N{x[N-1]}});

   // R4: an invertible map never sends a nonzero share to zero
   always_comb begin
      if (x != '0) begin
         assert_lin_nonzero_R4: assert (y != '0);
      end
   end

endmodule

// File: rtl/ti_spn_sbox.sv
module ti_spn_sbox
   import ti_sbox_pkg::*;
#(
   parameter int           N      = 4,
   parameter int           ROUNDS = 2,
   parameter logic [N-1:0] K      = 4'hF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [N-1:0] sh_in0,
   input  logic [N-1:0] sh_in1,
   input  logic [N-1:0] sh_in2,
   output logic [N-1:0] sh_out0,
   output logic [N-1:0] sh_out1,
   output logic [N-1:0] sh_out2,
   output logic         busy,
   output logic         done
);

   localparam int BW       = (N > 1) ? $clog2(N) : 1;
   localparam int RW       = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
   localparam int NL_STEPS = NUM_SHARES * N;
   localparam int TOTAL    = ROUNDS * (NL_STEPS + 2);
   localparam int LW       = $clog2(TOTAL + 1);

   if (ROUNDS < 1) begin : g_chk_rounds
      $error("ti_spn_sbox: ROUNDS must be at least 1");
   end

   ti_phase_e                       phase_q;
   logic [BW-1:0]                   bit_q;
   logic [1:0]                      shr_q;
   logic [RW-1:0]                   rnd_q;
   logic                            lin_q;
   logic                            done_q;
   logic [NUM_SHARES-1:0][N-1:0]    src_q;
   logic [NUM_SHARES-1:0][N-1:0]    dst_q;

   logic [N-1:0]                    opa, opb, opa_r, opb_r;
   logic                            g_bit;
   logic [NUM_SHARES-1:0][N-1:0]    lin_in, lin_out;
   logic                            last_rnd;
   logic                            bit_end;

   assign last_rnd = (rnd_q == RW'(ROUNDS - 1));
   assign bit_end  = (bit_q == BW'(N - 1));

   // operand select: output share j sees only shares j+1 and j+2
   always_comb begin
      unique case (shr_q)
         2'd0:    begin opa = src_q[1]; opb = src_q[2]; end
         2'd1:    begin opa = src_q[2]; opb = src_q[0]; end
         default: begin opa = src_q[0]; opb = src_q[1]; end
      endcase
   end

   ti_sbox_rot #(.N(N), .AW(BW)) u_rot_a (.din(opa), .amt(bit_q), .dout(opa_r));
   ti_sbox_rot #(.N(N), .AW(BW)) u_rot_b (.din(opb), .amt(bit_q), .dout(opb_r));

   ti_sbox_gadget #(.N(N)) u_gadget (.u(opa_r), .v(opb_r), .y(g_bit));

   // one diffusion unit per share; shares never meet
   for (genvar s = 0; s < NUM_SHARES; s++) begin : g_lin
      assign lin_in[s] = lin_q ? src_q[s] : dst_q[s];
      ti_sbox_lin #(.N(N), .K(K)) u_lin (.x(lin_in[s]), .y(lin_out[s]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         bit_q   <= '0;
         shr_q   <= '0;
         rnd_q   <= '0;
         lin_q   <= 1'b0;
         done_q  <= 1'b0;
         src_q   <= '0;
         dst_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  src_q[0] <= sh_in0;
                  src_q[1] <= sh_in1;
                  src_q[2] <= sh_in2;
                  bit_q    <= '0;
                  shr_q    <= '0;
                  rnd_q    <= '0;
                  phase_q  <= PH_NONLIN;
               end
            end
            PH_NONLIN: begin
               dst_q[shr_q][bit_q] <= g_bit;
               if (bit_end) begin
                  bit_q <= '0;
                  if (shr_q == 2'd2) begin
                     shr_q   <= '0;
                     lin_q   <= 1'b0;
                     phase_q <= PH_LIN;
                  end else begin
                     shr_q <= shr_q + 2'd1;
                  end
               end else begin
                  bit_q <= bit_q + BW'(1);
               end
            end
            PH_LIN: begin
               if (!lin_q) begin
                  src_q <= last_rnd ? dst_q : lin_out;
                  lin_q <= 1'b1;
               end else begin
                  lin_q <= 1'b0;
                  if (last_rnd) begin
                     phase_q <= PH_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     src_q   <= lin_out;
                     rnd_q   <= rnd_q + RW'(1);
                     phase_q <= PH_NONLIN;
                  end
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign busy    = (phase_q != PH_IDLE);
   assign done    = done_q;
   assign sh_out0 = src_q[0];
   assign sh_out1 = src_q[1];
   assign sh_out2 = src_q[2];

   // independent latency counter for the timing property
   logic [LW-1:0] lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lat_q <= '0;
      else if (!busy) lat_q <= '0;
      else            lat_q <= lat_q + LW'(1);
   end

   assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_q == LW'(TOTAL)));

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(sh_out0) && $stable(sh_out1) && $stable(sh_out2)));

endmodule

// File: tb/test_ti_spn_sbox.sv
module test_ti_spn_sbox;

   localparam int CLK_PERIOD = 10;
   localparam int LATENCY    = 28;
   localparam logic [3:0] EXP [16] = '{4'h0, 4'h4, 4'h8, 4'hA, 4'hF, 4'hC, 4'h6, 4'h9,
                                       4'h1, 4'hE, 4'hB, 4'hD, 4'h7, 4'h5, 4'h3, 4'h2};

   logic       clk = 1'b0;
   logic       rst_n;
   logic       start;
   logic [3:0] sh_in0, sh_in1, sh_in2;
   logic [3:0] sh_out0, sh_out1, sh_out2;
   logic       busy, done;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ti_spn_sbox i_ti_spn_sbox (
      .clk(clk), .rst_n(rst_n), .start(start),
      .sh_in0(sh_in0), .sh_in1(sh_in1), .sh_in2(sh_in2),
      .sh_out0(sh_out0), .sh_out1(sh_out1), .sh_out2(sh_out2),
      .busy(busy), .done(done)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_op(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c,
                         output int lat, output logic [3:0] o0, output logic [3:0] o1,
                         output logic [3:0] o2);
      @(negedge clk);
      sh_in0 = a; sh_in1 = b; sh_in2 = c; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 60) begin
         @(negedge clk);
         lat++;
      end
      o0 = sh_out0; o1 = sh_out1; o2 = sh_out2;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; start = 1'b0; sh_in0 = 4'h5; sh_in1 = 4'hA; sh_in2 = 4'h3;
      repeat (3) @(negedge clk);
      check("R1 busy in reset", int'(busy), 0);
      check("R1 done in reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 busy after reset", int'(busy), 0);
      check("R1 done after reset", int'(done), 0);
      check("R1 outputs after reset", int'({sh_out0, sh_out1, sh_out2}), 0);
   endtask

   task automatic t_accept();
      @(negedge clk);
      sh_in0 = 4'h1; sh_in1 = 4'h0; sh_in2 = 4'h0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2 busy after start", int'(busy), 1);
      while (busy) @(negedge clk);
   endtask

   // R4 R5: every value with several random sharings; R3 latency each time
   task automatic t_table();
      for (int x = 0; x < 16; x++) begin
         for (int m = 0; m < 4; m++) begin
            logic [3:0] m1, m2, o0, o1, o2;
            int lat;
            m1 = 4'($urandom); m2 = 4'($urandom);
            if (m == 0) begin m1 = 4'h0; m2 = 4'h0; end
            run_op(4'(x) ^ m1 ^ m2, m1, m2, lat, o0, o1, o2);
            check("R3 latency", lat, LATENCY);
            check("R3 busy low at done", int'(busy), 0);
            check(m == 0 ? "R4 recombined value" : "R5 mask independence",
                  int'(o0 ^ o1 ^ o2), int'(EXP[x]));
            @(negedge clk);
            check("R3 done single cycle", int'(done), 0);
         end
      end
   endtask

   task automatic t_zero();
      logic [3:0] o0, o1, o2;
      int lat;
      run_op(4'h0, 4'h0, 4'h0, lat, o0, o1, o2);
      check("R8 share0 zero", int'(o0), 0);
      check("R8 share1 zero", int'(o1), 0);
      check("R8 share2 zero", int'(o2), 0);
   endtask

   task automatic t_repeat();
      logic [3:0] a0, a1, a2, b0, b1, b2;
      int lat;
      run_op(4'h9, 4'h6, 4'hC, lat, a0, a1, a2);
      run_op(4'h0, 4'h0, 4'h0, lat, b0, b1, b2);
      run_op(4'h9, 4'h6, 4'hC, lat, b0, b1, b2);
      check("R9 share0 repeat", int'(b0), int'(a0));
      check("R9 share1 repeat", int'(b1), int'(a1));
      check("R9 share2 repeat", int'(b2), int'(a2));
   endtask

   task automatic t_start_busy();
      int lat;
      @(negedge clk);
      sh_in0 = 4'h7 ^ 4'h3 ^ 4'hE; sh_in1 = 4'h3; sh_in2 = 4'hE; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 60) begin
         if (lat == 6) begin
            sh_in0 = 4'hB; sh_in1 = 4'h2; sh_in2 = 4'h4; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      check("R6 latency with stray start", lat, LATENCY);
      check("R6 result with stray start", int'(sh_out0 ^ sh_out1 ^ sh_out2), int'(EXP[7]));
      @(negedge clk);
      check("R6 no second run", int'(busy), 0);
   endtask

   task automatic t_hold();
      logic [3:0] o0, o1, o2;
      int lat;
      run_op(4'hD ^ 4'h8 ^ 4'h1, 4'h8, 4'h1, lat, o0, o1, o2);
      sh_in0 = 4'hF; sh_in1 = 4'h0; sh_in2 = 4'h5;
      repeat (5) @(negedge clk);
      check("R7 share0 held", int'(sh_out0), int'(o0));
      check("R7 share1 held", int'(sh_out1), int'(o1));
      check("R7 share2 held", int'(sh_out2), int'(o2));
      check("R7 idle held", int'(busy), 0);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_accept();
      t_table();
      t_zero();
      t_repeat();
      t_start_busy();
      t_hold();
      summary();
      $finish;
   end

endmodule